// File: doc/BRIEF.md
# Display Controller Host Register Interface

This block sits between a host processor's register bus and the input FIFO of a display controller. The host picks a register with a small select field and strobes either a read or a write. One select code serves two registers. Reading it returns a status word that describes the display side. Writing it loads a control word whose only live field is an interrupt-enable flag. A second select code is a write-only data port. Each write to it passes one word to the display FIFO as a single-cycle valid pulse.

The display side reports three levels: the FIFO can accept a word, the FIFO looks empty, and the controller is busy. The block raises an interrupt request toward the host when the FIFO looks empty and the enable flag is set. Firmware services the interrupt by writing the control register with zero. This clears the enable and so withdraws the request. Data writes are never stalled. The host must poll the ready bit before it sends a word.

Top module: `dhr_host_regs`

## Requirements
- R1: A read strobe at select 5 puts the status word on `rdata_o` in the cycle after the strobe. Bit 3 is the interrupt-enable flag, bit 4 is FIFO-empty, bit 5 is display-busy, bit 6 is FIFO-ready, and bit 7 is the enable flag ANDed with FIFO-empty. All other bits read 0.
- R2: A write strobe at select 5 loads the enable flag from `wdata_i` bit 3 at that clock edge. All other written bits have no effect.
- R3: A write of all zeros at select 5 clears the enable flag, and `irq_o` is low from the next cycle on.
- R4: `irq_o` equals the enable flag ANDed with `disp_empty_i`, and it follows `disp_empty_i` with no register delay.
- R5: A write strobe at select 6 raises `disp_valid_o` for exactly one cycle, the cycle after the strobe, with `disp_data_o` equal to the written word. `disp_valid_o` is low in every other cycle.
- R6: A write at select 6 is forwarded as in R5 even while `disp_ready_i` is low.
- R7: Reset clears the enable flag, `disp_valid_o`, `rdata_o` and `irq_o`.
- R8: A read at any select other than 5, select 6 included, returns 0 in the cycle after the strobe. `rdata_o` is 0 in any cycle that does not follow a read strobe.
- R9: Writes at selects other than 5 and 6 change neither the enable flag nor the display outputs. A write at select 5 produces no `disp_valid_o` pulse, and a write at select 6 leaves the enable flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | SELW | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after `rd_i` |
| irq_o | output | 1 | Interrupt request to host |
| disp_ready_i | input | 1 | Display FIFO can accept a word |
| disp_empty_i | input | 1 | Display FIFO appears empty |
| disp_busy_i | input | 1 | Display controller busy |
| disp_data_o | output | DW | Word toward the display FIFO |
| disp_valid_o | output | 1 | One-cycle strobe for `disp_data_o` |

## Verification
The status read is tried with all eight combinations of ready, empty and busy, once with the enable clear and once with it set. This shows that each input reaches its own bit, and that bit 7 and `irq_o` depend on both the enable and empty. Control writes set only bit 3, then every bit except bit 3, then zero. This separates a decode of bit 3 from a decode of the whole word, and it confirms that a zero write withdraws the interrupt. Data writes use distinct words with ready both high and low, so a stall or a stale word shows up. Every unused select is both written and read, to catch a loose address decode.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
  localparam int unsigned BIT_EN    = 3;
  localparam int unsigned BIT_EMPTY = 4;
  localparam int unsigned BIT_BUSY  = 5;
  localparam int unsigned BIT_READY = 6;
  localparam int unsigned BIT_GATED = 7;
  localparam int unsigned MIN_DW    = 8;

  typedef struct packed {
    logic ready;
    logic busy;
    logic empty;
  } disp_flags_t;
endpackage

// File: rtl/dhr_ctrl_reg.sv
module dhr_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_d_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_o <= 1'b0;
    else if (load_i) en_o <= en_d_i;
  end
endmodule

// File: rtl/dhr_status.sv
module dhr_status
  import dhr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_stat_i,
  input  logic        en_i,
  input  disp_flags_t flags_i,
  output logic [DW-1:0] rdata_o
);
  function automatic logic [DW-1:0] pack_status(input logic en, input disp_flags_t f);
    logic [DW-1:0] w;
    w = '0;
    w[BIT_EN]    = en;
    w[BIT_EMPTY] = f.empty;
    w[BIT_BUSY]  = f.busy;
    w[BIT_READY] = f.ready;
    w[BIT_GATED] = en & f.empty;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_o <= '0;
    else if (rd_stat_i) rdata_o <= pack_status(en_i, flags_i);
    else                rdata_o <= '0;
  end
endmodule

// File: rtl/dhr_data_port.sv
module dhr_data_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= push_i;
      if (push_i) data_o <= word_i;
    end
  end
endmodule

// File: rtl/dhr_host_regs.sv
module dhr_host_regs
  import dhr_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned SELW     = 3,
  parameter int unsigned SEL_STAT = 5,
  parameter int unsigned SEL_DATA = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  input  logic            disp_ready_i,
  input  logic            disp_empty_i,
  input  logic            disp_busy_i,
  output logic [DW-1:0]   disp_data_o,
  output logic            disp_valid_o
);
  localparam logic [SELW-1:0] SEL_S = SELW'(SEL_STAT);
  localparam logic [SELW-1:0] SEL_D = SELW'(SEL_DATA);

  // named decode events, observed by the checker
  logic hit_stat;
  logic hit_data;
  logic ctl_wr;
  logic stat_rd;
  logic data_wr;
  logic en_q;
  disp_flags_t flags;

  assign hit_stat = (sel_i == SEL_S);
  assign hit_data = (sel_i == SEL_D);
  assign ctl_wr   = wr_i & hit_stat;
  assign stat_rd  = rd_i & hit_stat;
  assign data_wr  = wr_i & hit_data;

  assign flags.ready = disp_ready_i;
  assign flags.busy  = disp_busy_i;
  assign flags.empty = disp_empty_i;

  dhr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ctl_wr),
    .en_d_i (wdata_i[BIT_EN]),
    .en_o   (en_q)
  );

  dhr_status #(.DW(DW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stat_i (stat_rd),
    .en_i      (en_q),
    .flags_i   (flags),
    .rdata_o   (rdata_o)
  );

  dhr_data_port #(.DW(DW)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (data_wr),
    .word_i  (wdata_i),
    .data_o  (disp_data_o),
    .valid_o (disp_valid_o)
  );

  assign irq_o = en_q & flags.empty;

  initial begin
    if (DW < MIN_DW) $error("dhr_host_regs: DW must be at least %0d", MIN_DW);
  end
endmodule

// File: rtl/dhr_host_regs_chk.sv
module dhr_host_regs_chk #(
  parameter int unsigned DW       = 16,
  parameter int unsigned SELW     = 3,
  parameter int unsigned SEL_STAT = 5,
  parameter int unsigned SEL_DATA = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] sel_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_o,
  input logic            disp_empty_i,
  input logic [DW-1:0]   disp_data_o,
  input logic            disp_valid_o,
  input logic            en_q
);
  localparam logic [SELW-1:0] SS = SELW'(SEL_STAT);
  localparam logic [SELW-1:0] SD = SELW'(SEL_DATA);

  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SS) |=> (en_q == $past(wdata_i[3])));

  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SS && wdata_i == '0) |=> !irq_o);

  a_r4_no_irq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_empty_i |-> !irq_o);

  a_r5_push_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SD) |=> (disp_valid_o && disp_data_o == $past(wdata_i)));

  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel_i == SD) |=> !disp_valid_o);

  a_r1_gated_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == SS) |=> (rdata_o[7] == (rdata_o[3] && rdata_o[4])));

  a_r8_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && sel_i == SS) |=> (rdata_o == '0));

  a_r9_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel_i == SS) |=> $stable(en_q));
endmodule

bind dhr_host_regs dhr_host_regs_chk #(
  .DW(DW), .SELW(SELW), .SEL_STAT(SEL_STAT), .SEL_DATA(SEL_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_i(rd_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .disp_empty_i(disp_empty_i), .disp_data_o(disp_data_o),
  .disp_valid_o(disp_valid_o), .en_q(en_q)
);

// File: tb/dhr_host_regs_bench.sv
module dhr_host_regs_bench;
  localparam int DW = 16;
  localparam int SELW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [SELW-1:0] sel_i = '0;
  logic            rd_i = 1'b0;
  logic            wr_i = 1'b0;
  logic [DW-1:0]   wdata_i = '0;
  logic [DW-1:0]   rdata_o;
  logic            irq_o;
  logic            disp_ready_i = 1'b0;
  logic            disp_empty_i = 1'b0;
  logic            disp_busy_i = 1'b0;
  logic [DW-1:0]   disp_data_o;
  logic            disp_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dhr_host_regs u_dhr_host_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .disp_ready_i(disp_ready_i), .disp_empty_i(disp_empty_i),
    .disp_busy_i(disp_busy_i), .disp_data_o(disp_data_o),
    .disp_valid_o(disp_valid_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // bench's own status model: each flag placed by its bit weight
  function automatic logic [DW-1:0] model_status(input bit en, input bit rdy, input bit emp, input bit bsy);
    int v;
    v = (en ? 8 : 0) + (emp ? 16 : 0) + (bsy ? 32 : 0) + (rdy ? 64 : 0) + ((en && emp) ? 128 : 0);
    return DW'(v);
  endfunction

  task automatic bus_write(input int sel, input logic [DW-1:0] d);
    @(negedge clk);
    sel_i = SELW'(sel); wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_read(input int sel, output logic [DW-1:0] d);
    @(negedge clk);
    sel_i = SELW'(sel); rd_i = 1'b1;
    @(negedge clk);
    d = rdata_o; rd_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] r;
    disp_empty_i = 1'b1;
    #1;
    check("R7 rdata after reset", rdata_o, '0);
    check("R7 valid after reset", DW'(disp_valid_o), '0);
    check("R7 irq after reset", DW'(irq_o), '0);
    bus_read(5, r);
    check("R7 enable clear after reset", r, model_status(0, 0, 1, 0));
  endtask

  task automatic t_status_patterns;
    logic [DW-1:0] r;
    for (int en = 0; en < 2; en++) begin
      bus_write(5, en ? DW'(8) : DW'(0));
      for (int p = 0; p < 8; p++) begin
        disp_ready_i = p[0]; disp_empty_i = p[1]; disp_busy_i = p[2];
        bus_read(5, r);
        check("R1 status word", r, model_status(en[0], p[0], p[1], p[2]));
        check("R4 irq gate", DW'(irq_o), DW'(en[0] & p[1]));
        @(negedge clk);
        check("R8 idle rdata zero", rdata_o, '0);
      end
    end
  endtask

  task automatic t_enable;
    logic [DW-1:0] r;
    disp_ready_i = 1'b0; disp_busy_i = 1'b0; disp_empty_i = 1'b1;
    bus_write(5, DW'(0));
    bus_write(5, DW'(16'h0008));
    check("R2 bit3 alone sets enable", DW'(irq_o), DW'(1));
    disp_empty_i = 1'b0; #1;
    check("R4 irq follows empty low", DW'(irq_o), '0);
    disp_empty_i = 1'b1; #1;
    check("R4 irq follows empty high", DW'(irq_o), DW'(1));
    bus_write(5, ~DW'(16'h0008));
    bus_read(5, r);
    check("R2 other bits ignored", r, model_status(0, 0, 1, 0));
    bus_write(5, DW'(16'h0008));
    bus_write(5, DW'(0));
    check("R3 zero write drops irq", DW'(irq_o), '0);
    bus_read(5, r);
    check("R3 zero write clears enable", r, model_status(0, 0, 1, 0));
  endtask

  task automatic t_data;
    logic [DW-1:0] w [3] = '{DW'(16'hA5C3), DW'(16'h0001), DW'(16'hFFFF)};
    for (int i = 0; i < 3; i++) begin
      disp_ready_i = (i != 1);
      @(negedge clk);
      sel_i = 3'd6; wdata_i = w[i]; wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
      check(i == 1 ? "R6 push while not ready" : "R5 valid pulse", DW'(disp_valid_o), DW'(1));
      check(i == 1 ? "R6 word while not ready" : "R5 data word", disp_data_o, w[i]);
      @(negedge clk);
      check("R5 single-cycle pulse", DW'(disp_valid_o), '0);
    end
    bus_write(5, DW'(16'h0008));
    check("R9 control write no valid", DW'(disp_valid_o), '0);
    bus_write(6, DW'(0));
    disp_empty_i = 1'b1; #1;
    check("R9 data write keeps enable", DW'(irq_o), DW'(1));
    bus_write(5, DW'(0));
  endtask

  task automatic t_unused;
    logic [DW-1:0] r;
    disp_empty_i = 1'b1; disp_ready_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      if (s == 5) continue;
      bus_read(s, r);
      check("R8 other select reads zero", r, '0);
      if (s == 6) continue;
      bus_write(s, DW'(16'hFFFF));
      check("R9 unused write no valid", DW'(disp_valid_o), '0);
      check("R9 unused write keeps enable", DW'(irq_o), '0);
    end
    bus_read(5, r);
    check("R9 enable after unused writes", r, model_status(0, 1, 1, 0));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_patterns();
    t_enable();
    t_data();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule